// File: doc/BRIEF.md
# Rotating Tiled-View Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a 32-bit address in tiled space. The caller supplies the pixel format (8-bit, 16-bit, 32-bit or page), a 3-bit view code selecting one of eight rotations and mirrorings, and an (x, y) coordinate. The block mirrors the coordinate against per-format masks, optionally swaps the two axes, packs the result into a linear offset, and places the view and format codes in the upper address bits.

It also gives the line stride that goes with the chosen format and view, and a flag that marks a coordinate outside the range the format allows. The container width and height, in address bits, are parameters. The outputs can be registered (one cycle of latency) or left combinational. Translation of the tiled address to physical memory is done elsewhere.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] carry the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page.
- R2: Address bits [31:29] carry the 3-bit view code unchanged (0 = 0°, 3 = 180°, 6 = 90°, 5 = 270°, 2 = 0° mirrored, 1 = 180° mirrored, 7 = 90° mirrored, 4 = 270° mirrored).
- R3: The per-format discarded-bit counts (xs, ys) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (WBITS,HBITS) for page; the usable coordinate widths are xw = WBITS-xs and yw = HBITS-ys.
- R4: A coordinate with x above 2^xw-1 or y above 2^yw-1 raises the invalid flag and forces the whole address to 0; any in-range coordinate, the origin included, leaves the flag low.
- R5: View bit 1 replaces x with (2^xw-1) - x and view bit 0 replaces y with (2^yw-1) - y before packing.
- R6: With view bit 2 clear the packed offset is y*2^xw + x; with it set the offset is x*2^yw + y (mirrored values).
- R7: The packed offset is multiplied by 2^(xs+ys) and occupies the address bits below bit 27; unused bits between it and bit 27 are zero.
- R8: The stride is 2^(HBITS+xs) when view bit 2 is set and 2^(WBITS+ys) otherwise; it is always a single set bit.
- R9: With registered outputs, results appear one clock after the inputs are sampled, and a synchronous reset clears address, stride and flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Pixel format code |
| view_i | input | 3 | View code: bit 2 swap, bit 1 invert x, bit 0 invert y |
| x_i | input | WBITS | Pixel column |
| y_i | input | HBITS | Pixel row |
| addr_o | output | 32 | Tiled-space address |
| stride_o | output | 32 | Line stride in bytes of tiled space |
| invalid_o | output | 1 | Coordinate out of range for the format |

## Verification
On every cycle the assertions check that the code fields in the upper address bits follow the previous cycle's format and view, that a flagged coordinate yields a zero address, that the origin is never flagged, that 32-bit addresses keep their two low bits clear and that the stride is one-hot. The exact offset arithmetic — the mirroring, the axis swap and the per-format scaling for every view — is only shown by the bench's full sweep of a reduced container, where each coordinate of every format and view is compared with an arithmetic model, together with the reset and one-cycle latency scenarios.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_8    = 2'd0,
    FMT_16   = 2'd1,
    FMT_32   = 2'd2,
    FMT_PAGE = 2'd3
  } tva_fmt_e;

  localparam int VIEW_YINV = 0;
  localparam int VIEW_XINV = 1;
  localparam int VIEW_SWAP = 2;
  localparam int ADDR_W    = 32;
  localparam int CODE_LSB  = 27;
endpackage

// File: rtl/tva_geom.sv
module tva_geom #(
  parameter int WBITS = 15,
  parameter int HBITS = 12,
  localparam int SHW  = $clog2(WBITS + HBITS + 1)
) (
  input  logic [1:0]       fmt,
  output logic [SHW-1:0]   xs,
  output logic [SHW-1:0]   ys,
  output logic [SHW-1:0]   xw,
  output logic [SHW-1:0]   yw,
  output logic [WBITS-1:0] xmask,
  output logic [HBITS-1:0] ymask
);
  import tva_pkg::*;

  always_comb begin
    unique case (tva_fmt_e'(fmt))
      FMT_8:    begin xs = '0;          ys = '0;          end
      FMT_16:   begin xs = '0;          ys = SHW'(1);     end
      FMT_32:   begin xs = SHW'(1);     ys = SHW'(1);     end
      default:  begin xs = SHW'(WBITS); ys = SHW'(HBITS); end
    endcase
    xw    = SHW'(WBITS) - xs;
    yw    = SHW'(HBITS) - ys;
    xmask = {WBITS{1'b1}} >> xs;
    ymask = {HBITS{1'b1}} >> ys;
  end
endmodule

// File: rtl/tva_map.sv
module tva_map #(
  parameter int WBITS = 15,
  parameter int HBITS = 12,
  localparam int SHW  = $clog2(WBITS + HBITS + 1),
  localparam int OFFW = WBITS + HBITS
) (
  input  logic [WBITS-1:0] x,
  input  logic [HBITS-1:0] y,
  input  logic [2:0]       view,
  input  logic [SHW-1:0]   xs,
  input  logic [SHW-1:0]   ys,
  input  logic [SHW-1:0]   xw,
  input  logic [SHW-1:0]   yw,
  input  logic [WBITS-1:0] xmask,
  input  logic [HBITS-1:0] ymask,
  output logic [OFFW-1:0]  offset,
  output logic [31:0]      stride,
  output logic             bad
);
  import tva_pkg::*;

  logic [WBITS-1:0] xm;
  logic [HBITS-1:0] ym;
  logic [OFFW-1:0]  xe, ye, packed_off;
  logic [SHW:0]     scale, sh_swap, sh_norm;

  always_comb begin
    bad = (x > xmask) || (y > ymask);
    xm  = view[VIEW_XINV] ? (x ^ xmask) : x;
    ym  = view[VIEW_YINV] ? (y ^ ymask) : y;
    xe  = OFFW'(xm);
    ye  = OFFW'(ym);
    if (view[VIEW_SWAP]) packed_off = (xe << yw) + ye;
    else                 packed_off = (ye << xw) + xe;
    scale   = {1'b0, xs} + {1'b0, ys};
    offset  = packed_off << scale;
    sh_swap = (SHW+1)'(HBITS) + {1'b0, xs};
    sh_norm = (SHW+1)'(WBITS) + {1'b0, ys};
    stride  = view[VIEW_SWAP] ? (32'd1 << sh_swap) : (32'd1 << sh_norm);
  end
endmodule

// File: rtl/tva_outreg.sv
module tva_outreg #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] addr_d,
  input  logic [31:0] stride_d,
  input  logic        bad_d,
  output logic [31:0] addr_q,
  output logic [31:0] stride_q,
  output logic        bad_q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q   <= '0;
          stride_q <= '0;
          bad_q    <= 1'b0;
        end else begin
          addr_q   <= addr_d;
          stride_q <= stride_d;
          bad_q    <= bad_d;
        end
      end
    end else begin : g_wire
      assign addr_q   = addr_d;
      assign stride_q = stride_d;
      assign bad_q    = bad_d;
    end
  endgenerate
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int WBITS   = 15,
  parameter int HBITS   = 12,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fmt_i,
  input  logic [2:0]       view_i,
  input  logic [WBITS-1:0] x_i,
  input  logic [HBITS-1:0] y_i,
  output logic [31:0]      addr_o,
  output logic [31:0]      stride_o,
  output logic             invalid_o
);
  import tva_pkg::*;

  localparam int SHW  = $clog2(WBITS + HBITS + 1);
  localparam int OFFW = WBITS + HBITS;

  logic [SHW-1:0]   xs, ys, xw, yw;
  logic [WBITS-1:0] xmask;
  logic [HBITS-1:0] ymask;
  logic [OFFW-1:0]  offset;
  logic [31:0]      stride_c, addr_c;
  logic             bad_c;

  tva_geom #(.WBITS(WBITS), .HBITS(HBITS)) u_geom (
    .fmt(fmt_i), .xs(xs), .ys(ys), .xw(xw), .yw(yw),
    .xmask(xmask), .ymask(ymask)
  );

  tva_map #(.WBITS(WBITS), .HBITS(HBITS)) u_map (
    .x(x_i), .y(y_i), .view(view_i), .xs(xs), .ys(ys), .xw(xw), .yw(yw),
    .xmask(xmask), .ymask(ymask), .offset(offset), .stride(stride_c),
    .bad(bad_c)
  );

  // Offset field is limited to bits below the code fields (WBITS+HBITS <= 27).
  assign addr_c = bad_c ? 32'd0 : {view_i, fmt_i, CODE_LSB'(offset)};

  tva_outreg #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .addr_d(addr_c), .stride_d(stride_c),
    .bad_d(bad_c), .addr_q(addr_o), .stride_q(stride_o), .bad_q(invalid_o)
  );

  generate
    if (REG_OUT) begin : g_chk
      // R1
      fmt_field_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (!invalid_o |-> addr_o[28:27] == $past(fmt_i)));
      // R2
      view_field_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (!invalid_o |-> addr_o[31:29] == $past(view_i)));
      // R4
      bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> addr_o == 32'd0);
      // R4
      origin_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (x_i == '0 && y_i == '0) |=> !invalid_o);
      // R7
      wide_align_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((!invalid_o && $past(fmt_i) == 2'd2) |-> addr_o[1:0] == 2'b00));
      // R8
      stride_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $countones(stride_o) == 1);
    end
  endgenerate
endmodule

// File: tb/tiled_view_addr_bench.sv
`timescale 1ns/1ps
module tiled_view_addr_bench;
  localparam int WB = 5;
  localparam int HB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    fmt_i = '0;
  logic [2:0]    view_i = '0;
  logic [WB-1:0] x_i = '0;
  logic [HB-1:0] y_i = '0;
  logic [31:0]   addr_o, stride_o;
  logic          invalid_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tiled_view_addr #(.WBITS(WB), .HBITS(HB), .REG_OUT(1'b1)) u_tiled_view_addr (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .view_i(view_i), .x_i(x_i), .y_i(y_i),
    .addr_o(addr_o), .stride_o(stride_o), .invalid_o(invalid_o)
  );

  function automatic longint pw2(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 2;
    return r;
  endfunction

  // Arithmetic model built from R3..R8
  task automatic model(input int f, input int v, input int x, input int y,
                       output longint ea, output longint es, output bit eb);
    int xs, ys, xw, yw, xm, ym;
    longint off;
    case (f)
      0: begin xs = 0;  ys = 0;  end
      1: begin xs = 0;  ys = 1;  end
      2: begin xs = 1;  ys = 1;  end
      default: begin xs = WB; ys = HB; end
    endcase
    xw = WB - xs;
    yw = HB - ys;
    eb = (x > pw2(xw) - 1) || (y > pw2(yw) - 1);
    xm = ((v / 2) % 2 == 1) ? int'(pw2(xw) - 1) - x : x;
    ym = (v % 2 == 1) ? int'(pw2(yw) - 1) - y : y;
    if (v >= 4) off = xm * pw2(yw) + ym;
    else        off = ym * pw2(xw) + xm;
    off = off * pw2(xs + ys);
    ea = eb ? 0 : (v * pw2(29) + f * pw2(27) + off);
    es = (v >= 4) ? pw2(HB + xs) : pw2(WB + ys);
  endtask

  task automatic check(input string tag, input longint ea, input longint es, input bit eb);
    vectors++;
    if (addr_o !== 32'(ea) || stride_o !== 32'(es) || invalid_o !== eb) begin
      miscompares++;
      $display("FAIL %s fmt=%0d view=%0d x=%0d y=%0d: addr=%h stride=%h bad=%b, expected addr=%h stride=%h bad=%b",
               tag, fmt_i, view_i, x_i, y_i, addr_o, stride_o, invalid_o,
               32'(ea), 32'(es), eb);
    end
  endtask

  function automatic string tag_for(input int v, input bit eb);
    if (eb)     return "R4";
    if (v >= 4) return "R6 R8 R2";
    if (v != 0) return "R5 R2";
    return "R1 R3 R7 R8";
  endfunction

  initial begin
    longint ea, es, ea2, es2;
    bit eb, eb2;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset", 0, 0, 1'b0);
    rst = 1'b0;

    // R1 R7 R8: spot value, 32-bit view 0 at (3,2): offset ((2*16)+3)*4 = 140
    fmt_i = 2'd2; view_i = 3'd0; x_i = 5'd3; y_i = 4'd2;
    @(negedge clk);
    check("R1 R7 R8 spot", 64'h1000008C, 64, 1'b0);

    // R4: page mode only accepts the origin
    fmt_i = 2'd3; view_i = 3'd6; x_i = 5'd0; y_i = 4'd0;
    @(negedge clk);
    check("R4 page origin", 64'hD8000000, pw2(HB + WB), 1'b0);
    x_i = 5'd1;
    @(negedge clk);
    check("R4 page offgrid", 0, pw2(HB + WB), 1'b1);

    // R9: one-cycle latency
    fmt_i = 2'd0; view_i = 3'd0; x_i = 5'd7; y_i = 4'd1;
    @(negedge clk);
    model(0, 0, 7, 1, ea, es, eb);
    fmt_i = 2'd1; view_i = 3'd3; x_i = 5'd9; y_i = 4'd5;
    #1 check("R9 hold", ea, es, eb);
    model(1, 3, 9, 5, ea2, es2, eb2);
    @(negedge clk);
    check("R9 update", ea2, es2, eb2);

    // Full sweep: every format, view and coordinate
    for (int f = 0; f < 4; f++)
      for (int v = 0; v < 8; v++)
        for (int y = 0; y < (1 << HB); y++)
          for (int x = 0; x < (1 << WB); x++) begin
            fmt_i = 2'(f); view_i = 3'(v); x_i = WB'(x); y_i = HB'(y);
            @(negedge clk);
            model(f, v, x, y, ea, es, eb);
            check(tag_for(v, eb), ea, es, eb);
          end

    // R9: synchronous reset clears outputs again
    rst = 1'b1;
    @(negedge clk);
    check("R9 rereset", 0, 0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule